// File: doc/BRIEF.md
# Transmit Data Chunk Framer

This block takes an outgoing Ethernet frame, one byte per beat on an AXI4-Stream input, and cuts it into fixed transmit chunks for a serial MAC-PHY link. Each chunk is one 32-bit header word followed by a 64-byte payload. The block sends every chunk as seventeen 32-bit words on a valid/ready output, header first. The header tells the device whether the payload carries frame data, and marks where a frame starts and where its last byte falls.

The device grants transmit credits. The block starts a data chunk only while it holds at least one credit. The receive side may report chunks waiting in the device. When no data chunk can start, the block sends empty chunks, one for each pending receive chunk, so that the device can clock them out. Both counts are loaded from a buffer status value and are then replaced by the counts in each received footer. A footer that reports a transmit error aborts the frame in progress.

Each frame begins in a fresh chunk. The payload is assembled in a chunk buffer before the header is sent, because the header depends on where the frame ends.

Top module: `ctf_tx_framer`

## Requirements
- R1: A chunk is 17 output words: the header, then 16 payload words. Payload byte k goes to word k/4, in bits [31-8*(k%4) -: 8], so the earliest byte is most significant. Payload bytes after a frame's last byte are zero.
- R2: Header bit fields are: 31 = 1 (data chunk marker), 30 = sequence, 29 = 0, 28 = data valid, 27 = start valid, 26:23 = start word offset, 22 = end valid, 21:16 = end byte offset, 15:1 = 0. Bit 0 makes the count of ones in the header odd.
- R3: The chunk holding a frame's first byte has start valid = 1 and start word offset = 0. Later chunks of the same frame have start valid = 0.
- R4: The chunk holding a frame's last byte has end valid = 1 and end byte offset = payload index of that byte. A chunk closes at tlast or after 64 bytes. A 64-byte frame fits in one chunk with offset 63.
- R5: A data chunk starts only while transmit credits are non-zero. Each completed data chunk uses one credit. With zero credits, s_tready stays low and no data chunk is sent.
- R6: A buffer status load sets both the transmit credit count and the pending receive count. A footer replaces both counts. A footer takes priority over a load in the same cycle.
- R7: When pending receive chunks are non-zero and no data chunk can start, an empty chunk is sent. Its header has data valid = 0 and zero fields apart from bits 31, 30 and 0, and its payload is all zero. Every completed chunk lowers the pending receive count by one, floored at zero. Empty chunks use no credits.
- R8: The sequence bit is 0 for the first chunk after reset and toggles after every chunk.
- R9: A footer with the transmit error flag, arriving while a frame is partly accepted, discards the rest of that frame up to its tlast. It also discards an unsent partial chunk. A flagged footer arriving outside a frame only updates the counts.
- R10: While m_valid is high and m_ready is low, m_valid stays high and m_data holds its value.
- R11: During reset and with no credits or pending receive chunks, m_valid and s_tready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tdata | input | 8 | Frame byte |
| s_tvalid | input | 1 | Frame byte valid |
| s_tready | output | 1 | Frame byte accepted |
| s_tlast | input | 1 | Last byte of frame |
| m_data | output | 32 | Chunk word (header or payload) |
| m_valid | output | 1 | Chunk word valid |
| m_ready | input | 1 | Chunk word accepted |
| bsr_valid | input | 1 | Load counts from buffer status |
| bsr_tx_credits | input | CW | Buffer status transmit credits |
| bsr_rx_chunks | input | CW | Buffer status pending receive chunks |
| ftr_valid | input | 1 | Received footer strobe |
| ftr_tx_credits | input | CW | Footer transmit credits |
| ftr_rx_chunks | input | CW | Footer pending receive chunks |
| ftr_tx_err | input | 1 | Footer transmit error flag |

## Verification
The bench checks these corner cases:
- **Exactly 64 bytes.** An off-by-one in closing the chunk would spill a second chunk or put the wrong end offset.
- **Frame spanning chunks.** The start flag must not reappear in the continuation chunk.
- **Credits running out mid-frame.** The framer must stall between chunks, not send past zero.
- **Mix of data and empty chunks.** Each is checked against the shared receive count, so a design that fails to decrement on data chunks would send extra empty chunks.
- **Transmit error in three places.** While the frame waits for credits, during chunk filling, and outside any frame. A wrong design would send stale bytes, swallow the next frame, or lose the credit update.
- **Output backpressure.** The held word must stay stable.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2,
        ST_DROP = 2'd3
    } ctf_state_e;

    // Header word: marker, sequence, data/start/end flags, offsets, odd parity in bit 0
    function automatic logic [31:0] ctf_hdr(input logic seq, input logic dv, input logic sv,
                                            input logic [3:0] swo, input logic ev,
                                            input logic [5:0] ebo);
        logic [31:0] h;
        h        = '0;
        h[31]    = 1'b1;
        h[30]    = seq;
        h[28]    = dv;
        h[27]    = sv;
        h[26:23] = swo;
        h[22]    = ev;
        h[21:16] = ebo;
        h[0]     = ~(^h[31:1]);
        return h;
    endfunction

endpackage

// File: rtl/ctf_credit_ctr.sv
module ctf_credit_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic          upd_en,
    input  logic [CW-1:0] upd_val,
    input  logic          take,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (upd_en)                         cnt_d = upd_val;
        else if (load_en)                   cnt_d = load_val;
        else if (take && cnt_q != '0)       cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // A footer value always wins (R6)
    p_footer_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> count == $past(upd_val));

    // A consumed chunk lowers the count by exactly one (R5)
    p_take_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !upd_en && !load_en && count != '0) |=> count == $past(count) - CW'(1));

    // Floor at zero (R7)
    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !upd_en && !load_en && count == '0) |=> count == '0);

endmodule

// File: rtl/ctf_chunk_buf.sv
module ctf_chunk_buf #(
    parameter int PAYLOAD_BYTES = 64,
    localparam int WORDS = PAYLOAD_BYTES / 4,
    localparam int BW    = $clog2(PAYLOAD_BYTES),
    localparam int RIW   = $clog2(WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [BW-1:0]  waddr,
    input  logic [7:0]     wbyte,
    input  logic [RIW-1:0] ridx,
    output logic [31:0]    rword
);
    logic [7:0] mem [PAYLOAD_BYTES];

    for (genvar i = 0; i < PAYLOAD_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[i] <= '0;
            else if (clr)                        mem[i] <= '0;
            else if (we && waddr == BW'(i))      mem[i] <= wbyte;
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            rword[31-8*b -: 8] = mem[{ridx, 2'(b)}];
        end
    end

endmodule

// File: rtl/ctf_tx_framer.sv
module ctf_tx_framer
    import ctf_pkg::*;
#(
    parameter int CW            = 6,
    parameter int PAYLOAD_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    s_tdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic          s_tlast,
    output logic [31:0]   m_data,
    output logic          m_valid,
    input  logic          m_ready,
    input  logic          bsr_valid,
    input  logic [CW-1:0] bsr_tx_credits,
    input  logic [CW-1:0] bsr_rx_chunks,
    input  logic          ftr_valid,
    input  logic [CW-1:0] ftr_tx_credits,
    input  logic [CW-1:0] ftr_rx_chunks,
    input  logic          ftr_tx_err
);
    localparam int WORDS = PAYLOAD_BYTES / 4;
    localparam int BW    = $clog2(PAYLOAD_BYTES);
    localparam int RIW   = $clog2(WORDS);
    localparam int WIW   = $clog2(WORDS + 1);

    typedef struct packed {
        ctf_state_e     st;
        logic [BW-1:0]  bcnt;
        logic [WIW-1:0] widx;
        logic           in_frame;
        logic           seq;
        logic           dv;
        logic           sv;
        logic           ev;
        logic [BW-1:0]  ebo;
        logic           drop;
    } ctf_regs_t;

    ctf_regs_t d, q;

    logic          buf_clr, buf_we, tx_take, rx_take, err_now;
    logic [RIW-1:0] rd_idx;
    logic [31:0]   rword, hdr;
    logic [CW-1:0] tx_cnt, rx_cnt;

    ctf_credit_ctr #(.CW(CW)) u_tx_credit (
        .clk(clk), .rst_n(rst_n),
        .load_en(bsr_valid), .load_val(bsr_tx_credits),
        .upd_en(ftr_valid),  .upd_val(ftr_tx_credits),
        .take(tx_take), .count(tx_cnt)
    );

    ctf_credit_ctr #(.CW(CW)) u_rx_pending (
        .clk(clk), .rst_n(rst_n),
        .load_en(bsr_valid), .load_val(bsr_rx_chunks),
        .upd_en(ftr_valid),  .upd_val(ftr_rx_chunks),
        .take(rx_take), .count(rx_cnt)
    );

    ctf_chunk_buf #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .we(buf_we), .waddr(q.bcnt), .wbyte(s_tdata),
        .ridx(rd_idx), .rword(rword)
    );

    always_comb begin
        d        = q;
        buf_clr  = 1'b0;
        buf_we   = 1'b0;
        tx_take  = 1'b0;
        rx_take  = 1'b0;
        s_tready = 1'b0;
        m_valid  = 1'b0;
        err_now  = ftr_valid && ftr_tx_err;
        rd_idx   = RIW'(q.widx - WIW'(1));
        hdr      = ctf_hdr(q.seq, q.dv, q.sv, 4'd0, q.ev, 6'(q.ebo));
        m_data   = (q.widx == '0) ? hdr : rword;

        case (q.st)
            ST_IDLE: begin
                if (err_now && q.in_frame) begin
                    d.st       = ST_DROP;
                    d.in_frame = 1'b0;
                end else if (tx_cnt != '0 && s_tvalid) begin
                    d.st    = ST_FILL;
                    buf_clr = 1'b1;
                    d.bcnt  = '0;
                    d.widx  = '0;
                    d.dv    = 1'b1;
                    d.sv    = 1'b0;
                    d.ev    = 1'b0;
                    d.ebo   = '0;
                end else if (rx_cnt != '0) begin
                    d.st    = ST_SEND;
                    buf_clr = 1'b1;
                    d.widx  = '0;
                    d.dv    = 1'b0;
                    d.sv    = 1'b0;
                    d.ev    = 1'b0;
                    d.ebo   = '0;
                end
            end
            ST_FILL: begin
                s_tready = 1'b1;
                if (s_tvalid) begin
                    buf_we = 1'b1;
                    d.bcnt = q.bcnt + BW'(1);
                    if (!q.in_frame) begin
                        d.sv       = 1'b1;
                        d.in_frame = 1'b1;
                    end
                    if (s_tlast) begin
                        d.ev       = 1'b1;
                        d.ebo      = q.bcnt;
                        d.in_frame = 1'b0;
                        d.st       = ST_SEND;
                    end else if (q.bcnt == BW'(PAYLOAD_BYTES - 1)) begin
                        d.st = ST_SEND;
                    end
                end
                if (err_now && (q.in_frame || s_tvalid)) begin
                    d.in_frame = 1'b0;
                    d.st       = (s_tvalid && s_tlast) ? ST_IDLE : ST_DROP;
                end
            end
            ST_SEND: begin
                m_valid = 1'b1;
                if (err_now && q.in_frame) d.drop = 1'b1;
                if (m_ready) begin
                    d.widx = q.widx + WIW'(1);
                    if (q.widx == WIW'(WORDS)) begin
                        tx_take = q.dv;
                        rx_take = 1'b1;
                        d.seq   = ~q.seq;
                        d.widx  = '0;
                        if (q.drop || (err_now && q.in_frame)) begin
                            d.st       = ST_DROP;
                            d.in_frame = 1'b0;
                            d.drop     = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_DROP: begin
                s_tready = 1'b1;
                if (s_tvalid && s_tlast) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // Held output word must not change (R10)
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // Header word carries odd parity (R2)
    p_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && q.widx == '0) |-> (^m_data) == 1'b1);

    // Empty chunk payload is zero (R7)
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && q.widx != '0 && !q.dv) |-> m_data == '0);

    // Input accepted only while no chunk is being sent (R5)
    p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> !m_valid);

endmodule

// File: tb/ctf_tx_framer_test.sv
module ctf_tx_framer_test;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    s_tdata = '0;
    logic          s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic [31:0]   m_data;
    logic          m_valid, m_ready = 1'b1;
    logic          bsr_valid = 1'b0, ftr_valid = 1'b0, ftr_tx_err = 1'b0;
    logic [CW-1:0] bsr_tx_credits = '0, bsr_rx_chunks = '0;
    logic [CW-1:0] ftr_tx_credits = '0, ftr_rx_chunks = '0;

    always #4 clk = ~clk;

    ctf_tx_framer #(.CW(CW), .PAYLOAD_BYTES(64)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
        .bsr_valid(bsr_valid), .bsr_tx_credits(bsr_tx_credits), .bsr_rx_chunks(bsr_rx_chunks),
        .ftr_valid(ftr_valid), .ftr_tx_credits(ftr_tx_credits), .ftr_rx_chunks(ftr_rx_chunks),
        .ftr_tx_err(ftr_tx_err)
    );

    int           n_checks = 0, n_fail = 0;
    logic [31:0]  exp_q[$];
    logic         exp_seq = 1'b0;
    string        tag = "R11";
    logic         bp_mode = 1'b0;
    int           bp_cnt = 0;
    int           cyc = 0;
    logic         prev_stall = 1'b0;
    logic [31:0]  prev_word = '0;
    logic         done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Header built from the R2 field list
    function automatic logic [31:0] mk_hdr(input logic dv, input logic sv, input logic ev, input int ebo);
        logic [31:0] h;
        h = 32'h8000_0000;
        if (exp_seq) h = h | 32'h4000_0000;
        if (dv) h = h | 32'h1000_0000;
        if (sv) h = h | 32'h0800_0000;
        if (ev) h = h | 32'h0040_0000 | (32'(ebo) << 16);
        if ((^h) == 1'b0) h = h | 32'h1;
        return h;
    endfunction

    task automatic push_data(input logic [7:0] base, input int off, input int n, input logic sv, input logic ev);
        exp_q.push_back(mk_hdr(1'b1, sv, ev, n - 1));
        exp_seq = ~exp_seq;   // R8
        for (int w = 0; w < 16; w++) begin
            logic [31:0] wd;
            wd = '0;
            for (int b = 0; b < 4; b++) begin
                int k;
                k = w * 4 + b;
                if (k < n) wd[31-8*b -: 8] = 8'(base + 8'(off + k));
            end
            exp_q.push_back(wd);
        end
    endtask

    task automatic push_empty();
        exp_q.push_back(mk_hdr(1'b0, 1'b0, 1'b0, 0));
        exp_seq = ~exp_seq;
        for (int w = 0; w < 16; w++) exp_q.push_back(32'h0);
    endtask

    task automatic send_frame(input int len, input logic [7:0] base);
        for (int i = 0; i < len; i++) begin
            s_tvalid = 1'b1;
            s_tdata  = 8'(base + 8'(i));
            s_tlast  = (i == len - 1);
            do @(negedge clk); while (!s_tready);
            @(posedge clk); #1;
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic load_bsr(input int tx, input int rx);
        @(posedge clk); #1;
        bsr_valid = 1'b1; bsr_tx_credits = CW'(tx); bsr_rx_chunks = CW'(rx);
        @(posedge clk); #1;
        bsr_valid = 1'b0;
    endtask

    task automatic footer(input int tx, input int rx, input logic err);
        @(posedge clk); #1;
        ftr_valid = 1'b1; ftr_tx_credits = CW'(tx); ftr_rx_chunks = CW'(rx); ftr_tx_err = err;
        @(posedge clk); #1;
        ftr_valid = 1'b0; ftr_tx_err = 1'b0;
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all expected words seen"}, 32'(exp_q.size()), 32'h0);
    endtask

    task automatic check_stall(input string req);
        @(negedge clk);
        check(!s_tready && !m_valid, req, {30'h0, s_tready, m_valid}, 32'h0);
    endtask

    always @(posedge clk) begin
        #1;
        bp_cnt++;
        m_ready = bp_mode ? (bp_cnt % 3 != 0) : 1'b1;
    end

    // Per-clock comparison against the reference word queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(m_valid && m_data == prev_word, "R10 held word", m_data, prev_word);
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {tag, " unexpected word"}, m_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(m_data == e, {tag, " R1 chunk word"}, m_data, e);
                end
            end
            prev_stall = m_valid && !m_ready;
            prev_word  = m_data;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check(!m_valid && !s_tready, "R11 in reset", {30'h0, s_tready, m_valid}, 32'h0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!m_valid && !s_tready, "R11 after reset", {30'h0, s_tready, m_valid}, 32'h0);

        // R3 R4 R8: short frame in one chunk
        tag = "R4";
        load_bsr(3, 0);
        push_data(8'h01, 0, 10, 1'b1, 1'b1);
        send_frame(10, 8'h01);
        drain();

        // R3 R10: frame across two chunks with output backpressure
        tag = "R3";
        bp_mode = 1'b1;
        load_bsr(2, 0);
        push_data(8'h20, 0, 64, 1'b1, 1'b0);
        push_data(8'h20, 64, 36, 1'b0, 1'b1);
        send_frame(100, 8'h20);
        drain();
        bp_mode = 1'b0;

        // R4: exactly one full payload
        tag = "R4";
        load_bsr(1, 0);
        push_data(8'h55, 0, 64, 1'b1, 1'b1);
        send_frame(64, 8'h55);
        drain();

        // R5 R6: credit gating refreshed by footers
        tag = "R5";
        load_bsr(0, 0);
        fork
            send_frame(70, 8'h10);
            begin
                repeat (20) @(posedge clk);
                check_stall("R5 no credit stall");
                push_data(8'h10, 0, 64, 1'b1, 1'b0);
                footer(1, 0, 1'b0);
                while (exp_q.size() != 0) @(negedge clk);
                repeat (20) @(posedge clk);
                check_stall("R5 credit used up");
                push_data(8'h10, 64, 6, 1'b0, 1'b1);
                footer(1, 0, 1'b0);
            end
        join
        drain();

        // R7: empty chunks for pending receive chunks only
        tag = "R7";
        load_bsr(0, 2);
        push_empty();
        push_empty();
        drain();

        // R7 R5: data chunk first, then empties; data chunk counts toward rx
        tag = "R7";
        fork
            send_frame(5, 8'h70);
            begin
                repeat (3) @(posedge clk);
                push_data(8'h70, 0, 5, 1'b1, 1'b1);
                push_empty();
                push_empty();
                load_bsr(1, 3);
            end
        join
        drain();

        // R6: footer beats buffer status in the same cycle
        tag = "R6";
        @(posedge clk); #1;
        bsr_valid = 1'b1; bsr_tx_credits = '0; bsr_rx_chunks = CW'(5);
        ftr_valid = 1'b1; ftr_tx_credits = '0; ftr_rx_chunks = CW'(1);
        @(posedge clk); #1;
        bsr_valid = 1'b0; ftr_valid = 1'b0;
        push_empty();
        drain();

        // R9: error while frame waits for credits
        tag = "R9";
        load_bsr(1, 0);
        fork
            send_frame(100, 8'h40);
            begin
                push_data(8'h40, 0, 64, 1'b1, 1'b0);
                while (exp_q.size() != 0) @(negedge clk);
                repeat (10) @(posedge clk);
                footer(2, 0, 1'b1);
            end
        join
        push_data(8'h90, 0, 4, 1'b1, 1'b1);
        send_frame(4, 8'h90);
        drain();

        // R9: error outside a frame only updates counts
        tag = "R9";
        footer(1, 0, 1'b1);
        push_data(8'h33, 0, 3, 1'b1, 1'b1);
        send_frame(3, 8'h33);
        drain();

        // R9: error during chunk filling discards partial chunk
        tag = "R9";
        load_bsr(1, 0);
        fork
            send_frame(40, 8'hA0);
            begin
                repeat (10) @(posedge clk);
                footer(1, 0, 1'b1);
            end
        join
        push_data(8'hB0, 0, 2, 1'b1, 1'b1);
        send_frame(2, 8'hB0);
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule